// File: doc/BRIEF.md
# Memory Bank Option Register with External Interrupt Sense Control

This block is a small control register on an 8-bit processor bus. Two of its bits choose whether RAM or ROM answers in two fixed low-address windows. The block decodes every incoming address against those windows and drives a RAM select or a ROM select for it. Both selects stay low for addresses outside the windows.

A third bit chooses how the active-low external interrupt pin is detected. The choices are falling edge only, or falling edge plus low level. The sense bit takes only the first register write after reset; from then on it is locked until the next reset. The sense bit cannot be read back.

The pin passes through a two-flop synchroniser. A falling edge on the synchronised pin sets a request latch, and the processor clears that latch with an acknowledge strobe. In edge-plus-level mode, the request also stays high for as long as the synchronised pin is low, whether or not an acknowledge arrives.

Top module: `memmap_opt_ctl`

## Requirements
- R1: After reset, rd_data reads 0x00, both bank bits select ROM, the sense mode is edge-plus-level, and irq_req is low while the pin is high.
- R2: rd_data bit 7 holds the value last written to wr_data bit 7. For addresses 0x0020 to 0x004F inclusive, ram_sel is high when this bit is 1 and rom_sel is high when it is 0.
- R3: rd_data bit 6 holds the value last written to wr_data bit 6. For addresses 0x0100 to 0x017F inclusive, ram_sel is high when this bit is 1 and rom_sel is high when it is 0.
- R4: For any address outside both windows, ram_sel and rom_sel are both low. The two selects are never high together.
- R5: rd_data bits 5 to 0 always read 0. This includes bit 1, which is the write-only sense bit.
- R6: Only the first write after reset loads the sense mode from wr_data bit 1 (1 = edge-plus-level, 0 = falling edge only). Every later write leaves the sense mode unchanged.
- R7: Only reset clears the write lock. After a new reset, the next write loads the sense mode again.
- R8: The pin passes through two synchroniser flops, and then the falling edge is detected. Suppose the pin goes low between clock edges k and k+1 while in falling-edge-only mode. Then irq_req is still low after edge k+2 and is high after edge k+3.
- R9: In falling-edge-only mode, the request stays high after the pin returns high. It clears on the edge where irq_ack is sampled high.
- R10: In edge-plus-level mode, irq_req stays high while the synchronised pin is low, even after an acknowledge. It drops once the pin has been high through both synchroniser stages and the latch has been acknowledged.
- R11: When a falling edge is detected on the same edge that irq_ack is sampled high, the set wins and irq_req stays high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, sampled on the rising clock edge |
| wr_data | input | 8 | Write data: bit 7 low window bank, bit 6 high window bank, bit 1 sense mode |
| rd_data | output | 8 | Register read image |
| addr | input | 16 | Bus address to decode |
| ram_sel | output | 1 | RAM answers for addr |
| rom_sel | output | 1 | ROM answers for addr |
| irq_pin_n | input | 1 | Asynchronous active-low external interrupt pin |
| irq_ack | input | 1 | Interrupt acknowledge strobe from the processor |
| irq_req | output | 1 | Interrupt request to the processor |

## Verification
The assertions assume that wr_en, wr_data, addr and irq_ack are synchronous to clk and stable at each rising edge. Only irq_pin_n may change without reference to the clock. The bench meets this by driving every input one nanosecond after a rising edge and sampling outputs at the falling edge. It moves the pin only at those same times, so the synchroniser delay it counts is exact. Acknowledge pulses last exactly one clock, which fits the assumption that the processor raises an acknowledge once per serviced request.

// File: rtl/memmap_opt_pkg.sv
package memmap_opt_pkg;
   localparam int unsigned OPT_DATA_W   = 8;
   localparam int unsigned BIT_BANK_LO  = 7;
   localparam int unsigned BIT_BANK_HI  = 6;
   localparam int unsigned BIT_SENSE    = 1;
   localparam int unsigned NUM_WIN      = 2;

   typedef enum logic {
      SENSE_FALL_ONLY  = 1'b0,
      SENSE_FALL_LEVEL = 1'b1
   } sense_e;
endpackage

// File: rtl/memmap_opt_reg.sv
module memmap_opt_reg
   import memmap_opt_pkg::*;
#(
   parameter int unsigned DATA_W = OPT_DATA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic [NUM_WIN-1:0] bank_ram,
   output sense_e            sense,
   output logic              locked,
   output logic [DATA_W-1:0] rd_data
);
   if (DATA_W < 8) begin : g_bad_width
      $error("memmap_opt_reg: DATA_W must be at least 8");
   end

   logic   bank_lo_q, bank_hi_q, lock_q;
   sense_e sense_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bank_lo_q <= 1'b0;
         bank_hi_q <= 1'b0;
         sense_q   <= SENSE_FALL_LEVEL;
         lock_q    <= 1'b0;
      end else if (wr_en) begin
         bank_lo_q <= wr_data[BIT_BANK_LO];
         bank_hi_q <= wr_data[BIT_BANK_HI];
         if (!lock_q) begin
            sense_q <= sense_e'(wr_data[BIT_SENSE]);
            lock_q  <= 1'b1;
         end
      end
   end

   always_comb begin
      rd_data              = '0;
      rd_data[BIT_BANK_LO] = bank_lo_q;
      rd_data[BIT_BANK_HI] = bank_hi_q;
   end

   assign bank_ram = {bank_hi_q, bank_lo_q};
   assign sense    = sense_q;
   assign locked   = lock_q;
endmodule

// File: rtl/memmap_win_decode.sv
module memmap_win_decode
   import memmap_opt_pkg::*;
#(
   parameter int unsigned ADDR_W = 16,
   parameter logic [NUM_WIN*ADDR_W-1:0] WIN_LO = {16'h0100, 16'h0020},
   parameter logic [NUM_WIN*ADDR_W-1:0] WIN_HI = {16'h017F, 16'h004F}
) (
   input  logic [ADDR_W-1:0]  addr,
   input  logic [NUM_WIN-1:0] bank_ram,
   output logic               ram_sel,
   output logic               rom_sel
);
   logic [NUM_WIN-1:0] hit;

   for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
      localparam logic [ADDR_W-1:0] LO = WIN_LO[w*ADDR_W +: ADDR_W];
      localparam logic [ADDR_W-1:0] HI = WIN_HI[w*ADDR_W +: ADDR_W];
      if (LO > HI) begin : g_bad_range
         $error("memmap_win_decode: window low bound above high bound");
      end
      assign hit[w] = (addr >= LO) && (addr <= HI);
   end

   assign ram_sel = |(hit &  bank_ram);
   assign rom_sel = |(hit & ~bank_ram);
endmodule

// File: rtl/memmap_irq_sense.sv
module memmap_irq_sense
   import memmap_opt_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic   clk,
   input  logic   rst_n,
   input  logic   pin_n,
   input  logic   ack,
   input  sense_e sense,
   output logic   sync_low,
   output logic   req
);
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("memmap_irq_sense: SYNC_STAGES must be at least 2");
   end

   localparam int unsigned TAPS = SYNC_STAGES + 1;

   logic [TAPS-1:0] tap;
   logic            fall, latch_q;

   for (genvar s = 0; s < TAPS; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) tap[s] <= 1'b1;
            else        tap[s] <= pin_n;
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) tap[s] <= 1'b1;
            else        tap[s] <= tap[s-1];
      end
   end

   assign sync_low = ~tap[SYNC_STAGES-1];
   assign fall     = tap[SYNC_STAGES] & sync_low;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    latch_q <= 1'b0;
      else if (fall) latch_q <= 1'b1;
      else if (ack)  latch_q <= 1'b0;
   end

   assign req = latch_q | ((sense == SENSE_FALL_LEVEL) & sync_low);
endmodule

// File: rtl/memmap_opt_ctl.sv
module memmap_opt_ctl
   import memmap_opt_pkg::*;
#(
   parameter int unsigned ADDR_W      = 16,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic [OPT_DATA_W-1:0] wr_data,
   output logic [OPT_DATA_W-1:0] rd_data,
   input  logic [ADDR_W-1:0]     addr,
   output logic                  ram_sel,
   output logic                  rom_sel,
   input  logic                  irq_pin_n,
   input  logic                  irq_ack,
   output logic                  irq_req
);
   if (ADDR_W < 9) begin : g_bad_addr
      $error("memmap_opt_ctl: ADDR_W too narrow for the bank windows");
   end

   localparam logic [ADDR_W-1:0] LO0 = ADDR_W'(16'h0020);
   localparam logic [ADDR_W-1:0] HI0 = ADDR_W'(16'h004F);
   localparam logic [ADDR_W-1:0] LO1 = ADDR_W'(16'h0100);
   localparam logic [ADDR_W-1:0] HI1 = ADDR_W'(16'h017F);

   logic [NUM_WIN-1:0] bank_ram;
   sense_e             sense_mode;
   logic               locked;
   logic               sync_low;

   memmap_opt_reg #(.DATA_W(OPT_DATA_W)) u_reg (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_data  (wr_data),
      .bank_ram (bank_ram),
      .sense    (sense_mode),
      .locked   (locked),
      .rd_data  (rd_data)
   );

   memmap_win_decode #(
      .ADDR_W (ADDR_W),
      .WIN_LO ({LO1, LO0}),
      .WIN_HI ({HI1, HI0})
   ) u_dec (
      .addr     (addr),
      .bank_ram (bank_ram),
      .ram_sel  (ram_sel),
      .rom_sel  (rom_sel)
   );

   memmap_irq_sense #(.SYNC_STAGES(SYNC_STAGES)) u_irq (
      .clk      (clk),
      .rst_n    (rst_n),
      .pin_n    (irq_pin_n),
      .ack      (irq_ack),
      .sense    (sense_mode),
      .sync_low (sync_low),
      .req      (irq_req)
   );
endmodule

// File: rtl/memmap_opt_chk.sv
module memmap_opt_chk
   import memmap_opt_pkg::*;
(
   input logic                  clk,
   input logic                  rst_n,
   input logic                  wr_en,
   input logic [OPT_DATA_W-1:0] wr_data,
   input logic [OPT_DATA_W-1:0] rd_data,
   input logic                  ram_sel,
   input logic                  rom_sel,
   input logic                  irq_ack,
   input logic                  irq_req,
   input sense_e                sense_mode,
   input logic                  locked,
   input logic                  sync_low
);
   // R4
   sel_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(ram_sel && rom_sel));

   // R5
   rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_data[5:0] == 6'd0);

   // R2
   bank_lo_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> rd_data[BIT_BANK_LO] == $past(wr_data[BIT_BANK_LO]));

   // R3
   bank_hi_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> rd_data[BIT_BANK_HI] == $past(wr_data[BIT_BANK_HI]));

   // R6
   sense_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      locked |=> $stable(sense_mode));

   // R7
   lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      locked |=> locked);

   // R10
   level_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sense_mode == SENSE_FALL_LEVEL && sync_low) |-> irq_req);

   // R9
   edge_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sense_mode == SENSE_FALL_ONLY && $past(sense_mode) == SENSE_FALL_ONLY
       && $fell(irq_req)) |-> $past(irq_ack));
endmodule

bind memmap_opt_ctl memmap_opt_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .wr_en      (wr_en),
   .wr_data    (wr_data),
   .rd_data    (rd_data),
   .ram_sel    (ram_sel),
   .rom_sel    (rom_sel),
   .irq_ack    (irq_ack),
   .irq_req    (irq_req),
   .sense_mode (sense_mode),
   .locked     (locked),
   .sync_low   (sync_low)
);

// File: tb/memmap_opt_ctl_test.sv
module memmap_opt_ctl_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [7:0]  wr_data = 8'h00;
   logic [7:0]  rd_data;
   logic [15:0] addr = 16'h0030;
   logic        ram_sel, rom_sel;
   logic        irq_pin_n = 1'b1;
   logic        irq_ack = 1'b0;
   logic        irq_req;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   // behavioural reference state
   bit m_lo, m_hi, m_level, m_lock, m_pend;
   bit pin_q[$];

   always #2 clk = ~clk;

   memmap_opt_ctl uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .rd_data(rd_data), .addr(addr), .ram_sel(ram_sel), .rom_sel(rom_sel),
      .irq_pin_n(irq_pin_n), .irq_ack(irq_ack), .irq_req(irq_req)
   );

   always @(posedge clk) begin
      if (!rst_n) begin
         m_lo = 0; m_hi = 0; m_level = 1; m_lock = 0; m_pend = 0;
         pin_q = '{1'b1, 1'b1, 1'b1};
      end else begin
         if (pin_q[2] && !pin_q[1]) m_pend = 1;
         else if (irq_ack)          m_pend = 0;
         if (wr_en) begin
            m_lo = wr_data[7];
            m_hi = wr_data[6];
            if (!m_lock) begin m_level = wr_data[1]; m_lock = 1; end
         end
         pin_q.push_front(irq_pin_n);
         void'(pin_q.pop_back());
      end
   end

   task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && !done) begin
         bit in0, in1, eram, erom;
         string tg;
         in0 = (addr >= 16'h0020 && addr <= 16'h004F);
         in1 = (addr >= 16'h0100 && addr <= 16'h017F);
         eram = (in0 && m_lo) || (in1 && m_hi);
         erom = (in0 && !m_lo) || (in1 && !m_hi);
         tg = in0 ? "R2 select" : in1 ? "R3 select" : "R4 select";
         check("R5 read image", rd_data, {m_lo, m_hi, 6'd0});
         check(tg, {6'd0, ram_sel, rom_sel}, {6'd0, eram, erom});
         check("R8 request", {7'd0, irq_req},
               {7'd0, m_pend || (m_level && !pin_q[1])});
      end
   end

   task automatic step(int n = 1);
      repeat (n) begin @(posedge clk); #1; end
   endtask

   task automatic probe();
      @(negedge clk); #0.5;
   endtask

   task automatic write_reg(logic [7:0] d);
      wr_en = 1'b1; wr_data = d; step(); wr_en = 1'b0;
   endtask

   task automatic pulse_ack();
      irq_ack = 1'b1; step(); irq_ack = 1'b0;
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
   endtask

   initial begin
      #800000;
      if (!done) begin
         done = 1'b1;
         checks++; fails++;
         $display("FAIL watchdog expired, all R: actual=hung expected=finished");
         summary();
         $finish;
      end
   end

   initial begin
      step(3);
      rst_n = 1'b1;
      probe();
      // R1 reset image and outputs
      check("R1 read after reset", rd_data, 8'h00);
      check("R1 rom in low window", {7'd0, rom_sel}, 8'h01);
      check("R1 idle request", {7'd0, irq_req}, 8'h00);

      step();
      write_reg(8'hC0);   // both RAM, falling edge only, locks
      probe();
      check("R2 R3 readback", rd_data, 8'hC0);
      foreach (addr_list[i]) begin
         addr = addr_list[i];
         probe();
         step();
      end
      addr = 16'h0020; probe();
      check("R2 low bound ram", {7'd0, ram_sel}, 8'h01);
      addr = 16'h017F; probe();
      check("R3 high bound ram", {7'd0, ram_sel}, 8'h01);
      addr = 16'h0180; probe();
      check("R4 outside", {6'd0, ram_sel, rom_sel}, 8'h00);
      step();
      write_reg(8'h40);
      addr = 16'h004F; probe();
      check("R2 low window rom", {6'd0, ram_sel, rom_sel}, 8'h01);
      addr = 16'h0100; probe();
      check("R3 high window ram", {6'd0, ram_sel, rom_sel}, 8'h02);

      // R8 sync latency in falling-edge mode
      step();
      irq_pin_n = 1'b0;          // after edge k
      step(2);                   // after k+2
      probe();
      check("R8 not yet at k+2", {7'd0, irq_req}, 8'h00);
      step();
      probe();
      check("R8 high at k+3", {7'd0, irq_req}, 8'h01);
      // R9 held after pin release, cleared by ack
      irq_pin_n = 1'b1;
      step(5);
      probe();
      check("R9 held without ack", {7'd0, irq_req}, 8'h01);
      pulse_ack();
      probe();
      check("R9 cleared by ack", {7'd0, irq_req}, 8'h00);

      // R6 later write cannot select level mode
      write_reg(8'hFE);
      probe();
      check("R6 R5 readback", rd_data, 8'hC0);
      irq_pin_n = 1'b0;
      step(4);
      pulse_ack();
      probe();
      check("R6 edge mode kept, pin low", {7'd0, irq_req}, 8'h00);
      irq_pin_n = 1'b1;
      step(3);

      // second reset: level mode, unlocked
      rst_n = 1'b0;
      step(2);
      rst_n = 1'b1;
      irq_pin_n = 1'b0;
      step(4);
      pulse_ack();
      probe();
      check("R10 level holds after ack", {7'd0, irq_req}, 8'h01);
      irq_pin_n = 1'b1;
      step(2);
      probe();
      check("R10 drops after pin high", {7'd0, irq_req}, 8'h00);

      // R7 lock cleared by reset: this write takes effect
      write_reg(8'h00);
      irq_pin_n = 1'b0;
      step(4);
      pulse_ack();
      probe();
      check("R7 new sense accepted", {7'd0, irq_req}, 8'h00);
      irq_pin_n = 1'b1;
      step(4);

      // R11 edge and ack on same edge
      irq_pin_n = 1'b0;          // after edge k
      step(2);
      irq_ack = 1'b1;            // sampled at k+3 with the edge
      step();
      irq_ack = 1'b0;
      probe();
      check("R11 set wins over ack", {7'd0, irq_req}, 8'h01);
      pulse_ack();
      irq_pin_n = 1'b1;
      step(3);

      done = 1'b1;
      summary();
      $finish;
   end

   logic [15:0] addr_list [8] = '{16'h001F, 16'h0020, 16'h004F, 16'h0050,
                                   16'h00FF, 16'h0100, 16'h017F, 16'h0180};
endmodule